// File: doc/BRIEF.md
# Consecutive-Fault Window Detector

This block watches a stream of light-sensor conversion results and reports when one chosen channel stays outside a programmable window. Each conversion delivers four channel results at once. Each result is a 4-bit scale exponent and a 20-bit mantissa. The detector selects one channel, expands it to a linear value, and compares it against a low bound and a high bound. Each bound is a 16-bit word: a 4-bit exponent in bits 15:12 and a 12-bit coarse result in bits 11:0.

A fault is only reported after a run of consecutive faulting conversions on the same side of the window. The run length is 1, 2, 4 or 8, picked by a 2-bit code. In latched mode a raised flag stays up until software pulses the clear strobe. In transparent mode the flags are re-evaluated on every conversion. The interrupt pin is asserted while either flag is up, with selectable polarity.

Results enter through a valid/ready pair. `in_ready` rises in the first clock after reset is released and then stays high, so the block never applies back-pressure. A conversion is taken in every cycle where `in_valid` and `in_ready` are both high. While `in_valid` is low the channel data is ignored. Suggested tie-offs for the bounds are 0x0000 for the low bound and 0xBFFF for the high bound.

Top module: `cfd_detector`

## Requirements
- R1: After reset both flags are 0, the interrupt pin is at its inactive level, and `in_ready` is 1 from the first clock after reset release.
- R2: A sample value is mantissa shifted left by its exponent. A bound value is its 12-bit result shifted left by 8 and then by its exponent.
- R3: A sample is a high fault only when its value is strictly greater than the high bound value; equality is not a fault.
- R4: A sample is a low fault only when its value is strictly less than the low bound value; equality is not a fault.
- R5: Fault-count code 0, 1, 2, 3 requires 1, 2, 4, 8 consecutive faults on a side before that side triggers.
- R6: A sample that is not a fault on a side restarts that side's consecutive count from zero.
- R7: `thr_ch_sel` (0..3) selects which channel is compared. Channel k occupies bits 24k+23:24k of `ch_res`, with the exponent in the top 4 bits of each 24-bit slice.
- R8: With `latch_en`=1 a triggered flag stays at 1 until a `flag_clr` pulse. A trigger in the same cycle as `flag_clr` leaves the flag at 1.
- R9: With `latch_en`=0 each accepted sample sets each flag to that side's trigger state for that sample.
- R10: `int_out` is 1 while a flag is up when `int_pol`=1, and is 0 while a flag is up when `int_pol`=0. It is the opposite level when no flag is up.
- R11: Without `in_valid`, faulting channel data changes neither flags nor counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_res | input | 96 | Four packed results, each {exponent[3:0], mantissa[19:0]} |
| in_valid | input | 1 | Conversion result present |
| in_ready | output | 1 | Block accepts results |
| thr_ch_sel | input | 2 | Channel compared against the window |
| thr_lo | input | 16 | Low bound {exponent, result} |
| thr_hi | input | 16 | High bound {exponent, result} |
| fault_code | input | 2 | Run-length code (1/2/4/8) |
| latch_en | input | 1 | 1 = latched flags, 0 = transparent |
| int_pol | input | 1 | Interrupt active level |
| flag_clr | input | 1 | Clear pulse for the flags |
| flag_hi | output | 1 | High-side flag |
| flag_lo | output | 1 | Low-side flag |
| int_out | output | 1 | Interrupt pin level |

## Verification
The window comparison is tried with values exactly on each bound, one unit beyond each bound, and values in different exponent/mantissa encodings of the same linear level. This separates strict from inclusive comparison and checks that the exponent is applied as a shift. Runs of faults one short of and exactly at each run length separate the four codes. A run broken by one in-window sample shows whether the count restarts. Faults placed on a single channel, together with changes of the selector, show which slice feeds the comparator. Latched and transparent sequences show when a flag is allowed to fall, including a clear in the same cycle as a trigger.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  parameter int CFD_EXP_W     = 4;
  parameter int CFD_MANT_W    = 20;
  parameter int CFD_THR_RES_W = 12;
  parameter int CFD_FC_W      = 2;
  parameter int CFD_NUM_CH    = 4;

  typedef enum logic {SIDE_LO = 1'b0, SIDE_HI = 1'b1} cfd_side_e;
endpackage

// File: rtl/cfd_value_scaler.sv
module cfd_value_scaler #(
  parameter int EXP_W  = 4,
  parameter int MANT_W = 20,
  parameter int OUT_W  = 35
) (
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  output logic [OUT_W-1:0]  value_o
);
  always_comb begin
    value_o = OUT_W'(mant_i) << exp_i;
  end
endmodule

// File: rtl/cfd_fault_run.sv
module cfd_fault_run #(
  parameter int FC_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_i,
  input  logic            fault_i,
  input  logic [FC_W-1:0] code_i,
  output logic            hit_o
);
  localparam int MAX_RUN = 1 << ((1 << FC_W) - 1);
  localparam int CNT_W   = $clog2(MAX_RUN) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] need;

  always_comb begin
    cnt_inc = (cnt_q == CNT_W'(MAX_RUN)) ? cnt_q : cnt_q + 1'b1;
    need    = CNT_W'(1) << code_i;
    hit_o   = sample_i && fault_i && (cnt_inc >= need);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (sample_i) cnt_q <= fault_i ? cnt_inc : '0;
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_RUN)); // R5
  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && !fault_i) |=> (cnt_q == '0)); // R6
  AST_RUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/cfd_detector.sv
module cfd_detector
  import cfd_pkg::*;
#(
  parameter int EXP_W     = CFD_EXP_W,
  parameter int MANT_W    = CFD_MANT_W,
  parameter int THR_RES_W = CFD_THR_RES_W,
  parameter int FC_W      = CFD_FC_W,
  parameter int NUM_CH    = CFD_NUM_CH,
  localparam int CH_W     = EXP_W + MANT_W,
  localparam int SEL_W    = $clog2(NUM_CH),
  localparam int THR_W    = EXP_W + THR_RES_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH*CH_W-1:0]  ch_res,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SEL_W-1:0]        thr_ch_sel,
  input  logic [THR_W-1:0]        thr_lo,
  input  logic [THR_W-1:0]        thr_hi,
  input  logic [FC_W-1:0]         fault_code,
  input  logic                    latch_en,
  input  logic                    int_pol,
  input  logic                    flag_clr,
  output logic                    flag_hi,
  output logic                    flag_lo,
  output logic                    int_out
);
  localparam int WIDE_W    = MANT_W + (1 << EXP_W) - 1;
  localparam int THR_SHIFT = MANT_W - THR_RES_W;

  logic [CH_W-1:0]   ch_arr [NUM_CH];
  logic [CH_W-1:0]   ch_pick;
  logic [WIDE_W-1:0] smp_val;
  logic [WIDE_W-1:0] bound_val [2];
  logic [THR_W-1:0]  bound_raw [2];
  logic              side_fault [2];
  logic              side_hit [2];
  logic              rdy_q;
  logic              fire;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_unpack
      assign ch_arr[gi] = ch_res[gi*CH_W +: CH_W];
    end
  endgenerate

  assign ch_pick  = ch_arr[thr_ch_sel];
  assign in_ready = rdy_q;
  assign fire     = in_valid && rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  cfd_value_scaler #(.EXP_W(EXP_W), .MANT_W(MANT_W), .OUT_W(WIDE_W)) u_smp_scale (
    .exp_i  (ch_pick[CH_W-1 -: EXP_W]),
    .mant_i (ch_pick[MANT_W-1:0]),
    .value_o(smp_val)
  );

  assign bound_raw[SIDE_LO] = thr_lo;
  assign bound_raw[SIDE_HI] = thr_hi;

  generate
    for (gi = 0; gi < 2; gi++) begin : g_side
      cfd_value_scaler #(.EXP_W(EXP_W), .MANT_W(MANT_W), .OUT_W(WIDE_W)) u_bound_scale (
        .exp_i  (bound_raw[gi][THR_W-1 -: EXP_W]),
        .mant_i ({bound_raw[gi][THR_RES_W-1:0], {THR_SHIFT{1'b0}}}),
        .value_o(bound_val[gi])
      );
      if (gi == SIDE_HI) begin : g_hi_cmp
        assign side_fault[gi] = smp_val > bound_val[gi];
      end else begin : g_lo_cmp
        assign side_fault[gi] = smp_val < bound_val[gi];
      end
      cfd_fault_run #(.FC_W(FC_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample_i(fire),
        .fault_i (side_fault[gi]),
        .code_i  (fault_code),
        .hit_o   (side_hit[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_hi <= 1'b0;
      flag_lo <= 1'b0;
    end else if (latch_en) begin
      if (side_hit[SIDE_HI])  flag_hi <= 1'b1;
      else if (flag_clr)      flag_hi <= 1'b0;
      if (side_hit[SIDE_LO])  flag_lo <= 1'b1;
      else if (flag_clr)      flag_lo <= 1'b0;
    end else begin
      if (fire) begin
        flag_hi <= side_hit[SIDE_HI];
        flag_lo <= side_hit[SIDE_LO];
      end else if (flag_clr) begin
        flag_hi <= 1'b0;
        flag_lo <= 1'b0;
      end
    end
  end

  assign int_out = int_pol ? (flag_hi | flag_lo) : ~(flag_hi | flag_lo);

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && flag_hi && !flag_clr) |=> flag_hi); // R8
  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && flag_clr && !fire) |=> (!flag_hi && !flag_lo)); // R8
  AST_TRANSP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_en && fire && !side_fault[SIDE_HI]) |=> !flag_hi); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !flag_clr) |=> ($stable(flag_hi) && $stable(flag_lo))); // R11
  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready); // R1
endmodule

// File: tb/cfd_detector_tb_top.sv
module cfd_detector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] ch_res = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  thr_ch_sel = 2'd0;
  logic [15:0] thr_lo = 16'h0001;
  logic [15:0] thr_hi = 16'h2010;
  logic [1:0]  fault_code = 2'd0;
  logic        latch_en = 1'b1;
  logic        int_pol = 1'b0;
  logic        flag_clr = 1'b0;
  logic        flag_hi, flag_lo, int_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfd_detector dut_i (
    .clk(clk), .rst_n(rst_n), .ch_res(ch_res), .in_valid(in_valid),
    .in_ready(in_ready), .thr_ch_sel(thr_ch_sel), .thr_lo(thr_lo),
    .thr_hi(thr_hi), .fault_code(fault_code), .latch_en(latch_en),
    .int_pol(int_pol), .flag_clr(flag_clr), .flag_hi(flag_hi),
    .flag_lo(flag_lo), .int_out(int_out)
  );

  // Bounds used: low = 0x001<<8 = 0x100, high = (0x010<<8)<<2 = 0x4000
  localparam logic [19:0] MID = 20'h02000;

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Put one value on channel ch (others in-window) and present one sample
  task automatic send(int ch, logic [3:0] e, logic [19:0] m);
    @(negedge clk);
    for (int k = 0; k < 4; k++) ch_res[k*24 +: 24] = {4'd0, MID};
    ch_res[ch*24 +: 24] = {e, m};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic clean();
    send(int'(thr_ch_sel), 4'd0, MID);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 flag_hi", flag_hi, 1'b0);
    check("R1 flag_lo", flag_lo, 1'b0);
    check("R1 int_out", int_out, 1'b1);
    check("R1 in_ready", in_ready, 1'b1);
  endtask

  task automatic t_compare();
    latch_en = 1'b0; fault_code = 2'd0;
    send(0, 4'd0, 20'h04000); check("R3 equal high", flag_hi, 1'b0);
    send(0, 4'd0, 20'h04001); check("R3 above high", flag_hi, 1'b1);
    send(0, 4'd3, 20'h00800); check("R2 scaled equal", flag_hi, 1'b0);
    send(0, 4'd1, 20'h02001); check("R2 scaled above", flag_hi, 1'b1);
    send(0, 4'd0, 20'h00100); check("R4 equal low", flag_lo, 1'b0);
    send(0, 4'd0, 20'h000FF); check("R4 below low", flag_lo, 1'b1);
    check("R4 high side quiet", flag_hi, 1'b0);
    thr_lo = 16'h1001; // 0x200
    send(0, 4'd0, 20'h001FF); check("R2 low bound exponent", flag_lo, 1'b1);
    thr_lo = 16'h0001;
    latch_en = 1'b1; clean();
  endtask

  task automatic t_runs();
    for (int c = 0; c < 4; c++) begin
      int need = 1 << c;
      fault_code = c[1:0];
      clean();
      for (int i = 0; i < need - 1; i++) send(0, 4'd0, 20'h08000);
      check($sformatf("R5 code %0d short run", c), flag_hi, 1'b0);
      send(0, 4'd0, 20'h08000);
      check($sformatf("R5 code %0d full run", c), flag_hi, 1'b1);
    end
    clean();
  endtask

  task automatic t_restart();
    fault_code = 2'd2;
    clean();
    for (int i = 0; i < 3; i++) send(0, 4'd0, 20'h00010);
    send(0, 4'd0, MID);
    for (int i = 0; i < 3; i++) send(0, 4'd0, 20'h00010);
    check("R6 broken run", flag_lo, 1'b0);
    send(0, 4'd0, 20'h00010);
    check("R6 run after restart", flag_lo, 1'b1);
    clean();
  endtask

  task automatic t_chsel();
    fault_code = 2'd0;
    thr_ch_sel = 2'd0; clean();
    send(2, 4'd0, 20'h08000);
    check("R7 other channel ignored", flag_hi, 1'b0);
    thr_ch_sel = 2'd2;
    send(2, 4'd0, 20'h08000);
    check("R7 selected channel", flag_hi, 1'b1);
    thr_ch_sel = 2'd3; clean();
    send(3, 4'd0, 20'h00001);
    check("R7 channel 3 low", flag_lo, 1'b1);
    thr_ch_sel = 2'd0; clean();
  endtask

  task automatic t_latch();
    latch_en = 1'b1; fault_code = 2'd0; clean();
    send(0, 4'd0, 20'h08000);
    send(0, 4'd0, MID);
    send(0, 4'd0, MID);
    check("R8 held after in-window", flag_hi, 1'b1);
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check("R8 cleared", flag_hi, 1'b0);
    @(negedge clk);
    ch_res[23:0] = {4'd0, 20'h08000};
    in_valid = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; flag_clr = 1'b0;
    check("R8 trigger beats clear", flag_hi, 1'b1);
    clean();
  endtask

  task automatic t_transparent();
    latch_en = 1'b0; fault_code = 2'd1;
    send(0, 4'd0, MID);
    send(0, 4'd0, 20'h08000);
    check("R9 one of two", flag_hi, 1'b0);
    send(0, 4'd0, 20'h08000);
    check("R9 two of two", flag_hi, 1'b1);
    send(0, 4'd0, MID);
    check("R9 drops in-window", flag_hi, 1'b0);
    latch_en = 1'b1; fault_code = 2'd0; clean();
  endtask

  task automatic t_pol();
    int_pol = 1'b0;
    send(0, 4'd0, 20'h08000);
    check("R10 active low asserted", int_out, 1'b0);
    int_pol = 1'b1; #1;
    check("R10 active high asserted", int_out, 1'b1);
    clean();
    check("R10 active high idle", int_out, 1'b0);
    int_pol = 1'b0; #1;
  endtask

  task automatic t_valid();
    fault_code = 2'd0; clean();
    @(negedge clk);
    ch_res[23:0] = {4'd0, 20'h08000};
    repeat (3) @(negedge clk);
    check("R11 no valid no flag", flag_hi, 1'b0);
    fault_code = 2'd1;
    send(0, 4'd0, 20'h08000);
    check("R11 idle cycles did not count", flag_hi, 1'b0);
    fault_code = 2'd0; clean();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_compare();
    t_runs();
    t_restart();
    t_chsel();
    t_latch();
    t_transparent();
    t_pol();
    t_valid();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule